// File: doc/BRIEF.md
# Address-Generation Interlock Stall Unit

This unit sits at the issue point of a short in-order integer pipeline whose stages run decode, address generation, two cache cycles, execute and writeback. Each cycle the issue stage presents one candidate instruction: its operation class, the register it writes and the two registers it uses to form a memory address (base and index). The unit answers with a single issue enable. When the enable is low, the issue stage holds the same instruction and presents it again on the next cycle, so a bubble enters the pipeline.

Two conditions hold an instruction back. The first is an address-generation interlock. A consumer that forms an address from a register written by a recent producer must wait a distance that depends on the producer's class: five cycles after an ordinary integer result, three after a load (its result is forwarded into address generation) and two after a load-address result (forwarded earlier still). The unit remembers the destinations of the most recent producers together with their required distance and age. The second condition is execute-unit occupancy. Multi-cycle operations keep the single execute unit for two, five or ten cycles, and no further instruction issues until the unit is free again.

Top module: `agi_issue_ctl`

## Requirements
- R1: `issue_en` is high only when `in_valid` is high; with no dependency and a free execute unit, a valid instruction issues in the same cycle it is presented.
- R2: `in_class` uses 0 register integer, 1 address integer, 2 load, 3 store, 4 load-address, 5 semaphore, 6 call or short multiply, 7 divide or long multiply. Classes 1, 2, 3, 4 and 6 are address consumers, and both `in_src_a` and `in_src_b` are compared for them.
- R3: When an instruction of class 0, 1, 5, 6 or 7 issues in cycle t and writes register r, an address consumer that reads r cannot issue before cycle t+5.
- R4: When a load (class 2) issues in cycle t and writes r, an address consumer that reads r cannot issue before cycle t+3, and it issues at t+3 if nothing else blocks it.
- R5: When a load-address (class 4) issues in cycle t and writes r, an address consumer that reads r stalls at t+1 and can issue at t+2.
- R6: Register 0 never creates a dependency, neither as a destination nor as a source. A store (class 3) records no destination, so its `in_dst` value has no effect.
- R7: Classes 0, 5 and 7 are never held back by register dependencies, even if their source fields match a recent destination.
- R8: After an instruction issues in cycle t, the next issue is no earlier than t+N. N is 1 for classes 0 to 4, 2 for class 5, 5 for class 6 and 10 for class 7.
- R9: Dependency distances are counted in clock cycles from the producer's issue. Idle cycles and stall cycles both count toward the distance.
- R10: A synchronous reset (`rst` high at a rising edge) forgets all producers and frees the execute unit, so a valid instruction issues in the first cycle after reset.
- R11: The five most recent producers are all tracked. When five producers issue back to back, the first one no longer blocks a consumer in the cycle after the fifth, while the fifth still does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A candidate instruction is presented |
| in_class | input | 3 | Operation class of the candidate (encoding in R2) |
| in_dst | input | 5 | Register written by the candidate (0 = none) |
| in_src_a | input | 5 | Base register used for address formation |
| in_src_b | input | 5 | Index register used for address formation |
| issue_en | output | 1 | The candidate issues in this cycle |

## Verification
The assertions assume that the candidate fields are stable around each rising edge and that every 3-bit class value has the meaning given in R2. They also assume that reset is held high across at least one rising edge before normal operation starts. The stimulus changes inputs only on falling edges. While `issue_en` is low it presents the same instruction unchanged, as the issue stage would, and it starts each scenario from a reset so no earlier producer leaks into the next case.

// File: rtl/agi_pkg.sv
package agi_pkg;

    typedef enum logic [2:0] {
        OP_INT_REG   = 3'd0,
        OP_INT_AGEN  = 3'd1,
        OP_LOAD      = 3'd2,
        OP_STORE     = 3'd3,
        OP_LDADDR    = 3'd4,
        OP_SEMA      = 3'd5,
        OP_CALL_MUL  = 3'd6,
        OP_DIV_LMUL  = 3'd7
    } op_class_e;

    // classes whose base/index operands feed address generation
    function automatic logic is_addr_user(op_class_e c);
        return (c == OP_INT_AGEN) || (c == OP_LOAD) || (c == OP_STORE) ||
               (c == OP_LDADDR)   || (c == OP_CALL_MUL);
    endfunction

    // classes that leave a register result behind
    function automatic logic writes_reg(op_class_e c);
        return c != OP_STORE;
    endfunction

endpackage

// File: rtl/agi_dep_table.sv
module agi_dep_table #(
    parameter int REG_W  = 5,
    parameter int DEPTH  = 5,
    parameter int DIST_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [REG_W-1:0]  push_reg,
    input  logic [DIST_W-1:0] push_need,
    input  logic [REG_W-1:0]  chk_a,
    input  logic [REG_W-1:0]  chk_b,
    output logic              hazard
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic              valid;
        logic [REG_W-1:0]  rnum;
        logic [DIST_W-1:0] need;
        logic [DIST_W-1:0] age;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic [PTR_W-1:0]   wr;
    } table_t;

    table_t state_d, state_q;
    logic [DEPTH-1:0] hit;

    // per-entry hazard detection
    for (genvar i = 0; i < DEPTH; i++) begin : g_match
        logic live;
        logic src_hit;
        assign live    = state_q.ent[i].valid && (state_q.ent[i].age < state_q.ent[i].need);
        assign src_hit = ((chk_a != '0) && (chk_a == state_q.ent[i].rnum)) ||
                         ((chk_b != '0) && (chk_b == state_q.ent[i].rnum));
        assign hit[i]  = live && src_hit;
    end

    assign hazard = |hit;

    always_comb begin
        state_d = state_q;
        // ages move forward every cycle, issue or not
        for (int i = 0; i < DEPTH; i++) begin
            if (state_q.ent[i].valid) begin
                if (state_q.ent[i].age < state_q.ent[i].need) begin
                    state_d.ent[i].age = state_q.ent[i].age + 1'b1;
                end else begin
                    state_d.ent[i].valid = 1'b0;
                end
            end
        end
        if (push) begin
            state_d.ent[state_q.wr].valid = 1'b1;
            state_d.ent[state_q.wr].rnum  = push_reg;
            state_d.ent[state_q.wr].need  = push_need;
            state_d.ent[state_q.wr].age   = DIST_W'(1);
            if (state_q.wr == PTR_W'(DEPTH - 1)) begin
                state_d.wr = '0;
            end else begin
                state_d.wr = state_q.wr + 1'b1;
            end
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

endmodule

// File: rtl/agi_exec_busy.sv
module agi_exec_busy #(
    parameter int OCC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OCC_W-1:0] extra,
    output logic             busy
);

    typedef struct packed {
        logic [OCC_W-1:0] left;
    } busy_t;

    busy_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d.left = extra;
        end else if (state_q.left != '0) begin
            state_d.left = state_q.left - 1'b1;
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign busy = state_q.left != '0;

endmodule

// File: rtl/agi_issue_ctl.sv
module agi_issue_ctl
    import agi_pkg::*;
#(
    parameter int REG_W       = 5,
    parameter int DEPTH       = 5,
    parameter int DIST_GEN    = 5,
    parameter int DIST_LOAD   = 3,
    parameter int DIST_LDADDR = 2,
    parameter int OCC_SEMA    = 2,
    parameter int OCC_CALL    = 5,
    parameter int OCC_DIV     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_class,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src_a,
    input  logic [REG_W-1:0] in_src_b,
    output logic             issue_en
);

    localparam int DIST_MAX = (DIST_GEN > DIST_LOAD)
                              ? ((DIST_GEN > DIST_LDADDR) ? DIST_GEN : DIST_LDADDR)
                              : ((DIST_LOAD > DIST_LDADDR) ? DIST_LOAD : DIST_LDADDR);
    localparam int DIST_W   = $clog2(DIST_MAX + 1);
    localparam int OCC_W    = $clog2(OCC_DIV + 1);

    typedef struct packed {
        logic              consumer;
        logic              push;
        logic [DIST_W-1:0] need;
        logic [OCC_W-1:0]  extra;
    } decode_t;

    op_class_e cls;
    decode_t   dec;
    logic      dep_hazard;
    logic      exec_busy;

    assign cls = op_class_e'(in_class);

    always_comb begin
        dec          = '0;
        dec.consumer = is_addr_user(cls);
        unique case (cls)
            OP_LOAD:     dec.need = DIST_W'(DIST_LOAD);
            OP_LDADDR:   dec.need = DIST_W'(DIST_LDADDR);
            default:     dec.need = DIST_W'(DIST_GEN);
        endcase
        unique case (cls)
            OP_SEMA:     dec.extra = OCC_W'(OCC_SEMA - 1);
            OP_CALL_MUL: dec.extra = OCC_W'(OCC_CALL - 1);
            OP_DIV_LMUL: dec.extra = OCC_W'(OCC_DIV - 1);
            default:     dec.extra = '0;
        endcase
        issue_en = in_valid && !exec_busy && !(dec.consumer && dep_hazard);
        dec.push = issue_en && writes_reg(cls) && (in_dst != '0);
    end

    agi_dep_table #(
        .REG_W (REG_W),
        .DEPTH (DEPTH),
        .DIST_W(DIST_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .push     (dec.push),
        .push_reg (in_dst),
        .push_need(dec.need),
        .chk_a    (in_src_a),
        .chk_b    (in_src_b),
        .hazard   (dep_hazard)
    );

    agi_exec_busy #(
        .OCC_W(OCC_W)
    ) u_busy (
        .clk  (clk),
        .rst  (rst),
        .start(issue_en),
        .extra(dec.extra),
        .busy (exec_busy)
    );

endmodule

// File: rtl/agi_issue_ctl_chk.sv
module agi_issue_ctl_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       in_class,
    input logic [REG_W-1:0] in_dst,
    input logic [REG_W-1:0] in_src_a,
    input logic [REG_W-1:0] in_src_b,
    input logic             issue_en,
    input logic             exec_busy
);

    logic cons_now;
    assign cons_now = (in_class == 3'd1) || (in_class == 3'd2) || (in_class == 3'd3) ||
                      (in_class == 3'd4) || (in_class == 3'd6);

    // R1
    issue_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        issue_en |-> in_valid);

    // R8
    busy_blocks_issue_chk: assert property (@(posedge clk) disable iff (rst)
        exec_busy |-> !issue_en);

    // R8
    long_op_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_en && in_class == 3'd7) |=> (exec_busy && !issue_en));

    // R5
    ldaddr_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_en && in_class == 3'd4 && in_dst != '0) |=>
        !(issue_en && cons_now &&
          (in_src_a == $past(in_dst) || in_src_b == $past(in_dst))));

    // R3
    general_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_en && (in_class == 3'd0 || in_class == 3'd1) && in_dst != '0) |=>
        !(issue_en && cons_now &&
          (in_src_a == $past(in_dst) || in_src_b == $past(in_dst))));

    // R7
    nonconsumer_free_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !exec_busy && !cons_now) |-> issue_en);

    // R6
    zero_source_free_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !exec_busy && in_src_a == '0 && in_src_b == '0) |-> issue_en);

    // R10
    reset_frees_unit_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !exec_busy);

endmodule

bind agi_issue_ctl agi_issue_ctl_chk #(.REG_W(REG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_class (in_class),
    .in_dst   (in_dst),
    .in_src_a (in_src_a),
    .in_src_b (in_src_b),
    .issue_en (issue_en),
    .exec_busy(exec_busy)
);

// File: tb/agi_issue_ctl_test.sv
module agi_issue_ctl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [2:0] in_class = 3'd0;
    logic [4:0] in_dst = 5'd0;
    logic [4:0] in_src_a = 5'd0;
    logic [4:0] in_src_b = 5'd0;
    logic       issue_en;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    agi_issue_ctl uut (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_class(in_class),
        .in_dst  (in_dst),
        .in_src_a(in_src_a),
        .in_src_b(in_src_b),
        .issue_en(issue_en)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, cycles=%0d expected below 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    // present one candidate for one cycle and check the enable mid-cycle
    task automatic step(input logic v, input logic [2:0] c, input logic [4:0] d,
                        input logic [4:0] sa, input logic [4:0] sb,
                        input logic exp, input string tag);
        @(negedge clk);
        in_valid = v;
        in_class = c;
        in_dst   = d;
        in_src_a = sa;
        in_src_b = sb;
        #1;
        checks++;
        if (issue_en !== exp) begin
            fails++;
            $display("FAIL %s: issue_en=%0b expected %0b", tag, issue_en, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        step(1'b0, 3'd0, 5'd0, 5'd0, 5'd0, 1'b0, "R1 idle after reset");
        step(1'b1, 3'd2, 5'd0, 5'd1, 5'd2, 1'b1, "R10 first valid issues");
    endtask

    task automatic t_general();
        do_reset();
        step(1'b1, 3'd0, 5'd5, 5'd0, 5'd0, 1'b1, "R3 producer issues");
        for (int k = 1; k < 5; k++)
            step(1'b1, 3'd2, 5'd0, 5'd5, 5'd0, 1'b0, $sformatf("R3 stall k=%0d", k));
        step(1'b1, 3'd2, 5'd0, 5'd5, 5'd0, 1'b1, "R3 issue at distance 5");
    endtask

    task automatic t_load();
        do_reset();
        step(1'b1, 3'd2, 5'd7, 5'd0, 5'd0, 1'b1, "R4 load issues");
        for (int k = 1; k < 3; k++)
            step(1'b1, 3'd3, 5'd0, 5'd0, 5'd7, 1'b0, $sformatf("R4 stall k=%0d", k));
        step(1'b1, 3'd3, 5'd0, 5'd0, 5'd7, 1'b1, "R4 issue at distance 3");
    endtask

    task automatic t_ldaddr();
        do_reset();
        step(1'b1, 3'd4, 5'd9, 5'd0, 5'd0, 1'b1, "R5 load-address issues");
        step(1'b1, 3'd1, 5'd0, 5'd9, 5'd0, 1'b0, "R5 stall k=1");
        step(1'b1, 3'd1, 5'd0, 5'd9, 5'd0, 1'b1, "R5 issue at distance 2");
        // call is an address consumer too (R2)
        step(1'b1, 3'd4, 5'd10, 5'd0, 5'd0, 1'b1, "R2 load-address before call");
        step(1'b1, 3'd6, 5'd0, 5'd10, 5'd0, 1'b0, "R2 call waits on base");
        step(1'b1, 3'd6, 5'd0, 5'd10, 5'd0, 1'b1, "R2 call issues");
    endtask

    task automatic t_zero_and_store();
        do_reset();
        step(1'b1, 3'd3, 5'd8, 5'd0, 5'd0, 1'b1, "R6 store issues");
        step(1'b1, 3'd2, 5'd0, 5'd8, 5'd0, 1'b1, "R6 store dst ignored");
        step(1'b1, 3'd0, 5'd0, 5'd0, 5'd0, 1'b1, "R6 write to r0");
        step(1'b1, 3'd2, 5'd0, 5'd0, 5'd0, 1'b1, "R6 r0 source free");
    endtask

    task automatic t_nonconsumer();
        do_reset();
        step(1'b1, 3'd0, 5'd4, 5'd0, 5'd0, 1'b1, "R7 producer issues");
        step(1'b1, 3'd0, 5'd0, 5'd4, 5'd4, 1'b1, "R7 register op not held");
        step(1'b1, 3'd7, 5'd0, 5'd4, 5'd0, 1'b1, "R7 divide not held");
    endtask

    task automatic t_occupancy();
        do_reset();
        step(1'b1, 3'd5, 5'd0, 5'd0, 5'd0, 1'b1, "R8 semaphore issues");
        step(1'b1, 3'd0, 5'd0, 5'd0, 5'd0, 1'b0, "R8 sema busy k=1");
        step(1'b1, 3'd6, 5'd0, 5'd0, 5'd0, 1'b1, "R8 after sema / call issues");
        for (int k = 1; k < 5; k++)
            step(1'b1, 3'd0, 5'd0, 5'd0, 5'd0, 1'b0, $sformatf("R8 call busy k=%0d", k));
        step(1'b1, 3'd7, 5'd0, 5'd0, 5'd0, 1'b1, "R8 after call / divide issues");
        for (int k = 1; k < 10; k++)
            step(1'b1, 3'd0, 5'd0, 5'd0, 5'd0, 1'b0, $sformatf("R8 divide busy k=%0d", k));
        step(1'b1, 3'd0, 5'd0, 5'd0, 5'd0, 1'b1, "R8 after divide");
        step(1'b1, 3'd1, 5'd0, 5'd0, 5'd0, 1'b1, "R8 single-cycle back to back");
    endtask

    task automatic t_idle_ages();
        do_reset();
        step(1'b1, 3'd1, 5'd6, 5'd0, 5'd0, 1'b1, "R9 producer issues");
        for (int k = 1; k < 4; k++)
            step(1'b0, 3'd0, 5'd0, 5'd0, 5'd0, 1'b0, $sformatf("R9 idle k=%0d", k));
        step(1'b1, 3'd2, 5'd0, 5'd6, 5'd0, 1'b0, "R9 stall k=4");
        step(1'b1, 3'd2, 5'd0, 5'd6, 5'd0, 1'b1, "R9 issue k=5");
    endtask

    task automatic t_depth();
        do_reset();
        for (int i = 0; i < 5; i++)
            step(1'b1, 3'd0, 5'(11 + i), 5'd0, 5'd0, 1'b1, $sformatf("R11 producer %0d", i));
        step(1'b1, 3'd2, 5'd0, 5'd11, 5'd0, 1'b1, "R11 oldest satisfied");
        for (int k = 2; k < 5; k++)
            step(1'b1, 3'd2, 5'd0, 5'd15, 5'd0, 1'b0, $sformatf("R11 newest k=%0d", k));
        step(1'b1, 3'd2, 5'd0, 5'd15, 5'd0, 1'b1, "R11 newest satisfied");
    endtask

    task automatic t_mid_reset();
        do_reset();
        step(1'b1, 3'd0, 5'd20, 5'd0, 5'd0, 1'b1, "R10 producer before reset");
        step(1'b1, 3'd7, 5'd0, 5'd0, 5'd0, 1'b1, "R10 divide before reset");
        do_reset();
        step(1'b1, 3'd2, 5'd0, 5'd20, 5'd0, 1'b1, "R10 table and busy cleared");
    endtask

    initial begin
        t_reset_state();
        t_general();
        t_load();
        t_ldaddr();
        t_zero_and_store();
        t_nonconsumer();
        t_occupancy();
        t_idle_ages();
        t_depth();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule